// File: doc/BRIEF.md
# PCM Transmit Framer with Output Guard

This block is the digital transmit end of a voice codec channel that sits on a time-division PCM highway. One clock serves as both the master clock and the serial bit clock. An 8 kHz frame-sync input marks each frame. When the block sees the start of a sync pulse, it captures the encoded 8-bit sample, which the converter presents as a parallel byte. It then sends that byte out serially, most significant bit first. While the bits are on the line it holds an active-low timeslot strobe low. The width of the sync pulse sets the frame type. A one-clock pulse is an ordinary voice frame. A pulse of two clocks or more is a signaling frame, and in that frame the last bit slot carries the transmit signaling input instead of the sample LSB.

The same block decides when the serial data and strobe pins may drive the highway. The single enable `out_en` is meant for the tri-state pad cells outside the block. Four conditions keep the pins released:
- The power-up holdoff, which lasts a fixed number of frames.
- The active-high power-down input held low.
- Standby, entered when frame sync has been missing for a long time.
- A stopped master clock. A free-running watchdog oscillator detects this, so the release happens even with no master-clock edges.

After any release, the pins drive again only when two things hold: the clock is running and a fresh frame sync has arrived. The power-down input should have a pull-up at the pad, so that an undriven pin leaves the block active.

Top module: `pcm_tx_framer`

## Requirements
- R1: While reset is low, and after its release until the holdoff has run, `out_en` is 0 and `ts_n` is 1.
- R2: The first HOLD_FRAMES accepted frame syncs after reset leave `out_en` at 0. The next accepted sync sets `out_en` to 1 at the clock edge where that sync is first sampled high (edge E0).
- R3: Edge E0 captures `sample`. After edge E0+k, for k from 0 to 6, `dx` carries `sample[7-k]`, so the byte goes out MSB first, one bit per clock.
- R4: `ts_n` goes low at edge E0, stays low for exactly 8 clocks and goes high at edge E0+8.
- R5: After edge E0+7, `dx` carries the last bit slot. If `fs` was also high at edge E0+1 (a signaling frame), that slot holds `tx_sig`. If `fs` was low at E0+1 (a voice frame), it holds `sample[0]`.
- R6: A rising edge on `fs` while a frame is still shifting is ignored. The bits and the strobe timing of that frame do not change, and no second strobe follows.
- R7: `pdn_n` low drives `out_en` to 0 by the second clock edge. `out_en` stays 0 while `pdn_n` is low, and after `pdn_n` returns high it stays 0 until the next accepted sync.
- R8: If no sync is accepted for STBY_CYCLES clocks, `out_en` goes to 0. The next accepted sync sets it to 1 again.
- R9: If `clk` stops for LOSS_TICKS watchdog ticks, `out_en` goes to 0 with no `clk` edge needed. When `clk` runs again, `out_en` stays 0 until a fresh accepted sync.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock and serial bit clock |
| wdt_clk | input | 1 | Free-running watchdog oscillator |
| rst_n | input | 1 | Synchronous active-low reset |
| pdn_n | input | 1 | Power-down control, 1 = active |
| fs | input | 1 | Transmit frame sync; its width selects voice or signaling |
| sample | input | 8 | Encoded sample, captured at the start of a frame |
| tx_sig | input | 1 | Signaling bit for the last slot of a signaling frame |
| dx | output | 1 | Serial data, MSB first |
| ts_n | output | 1 | Timeslot strobe, low during the 8 bit times |
| out_en | output | 1 | Drive enable for the `dx` and `ts_n` pads |

## Verification
The bench aims at the last bit slot with both sync widths. A design that sampled the width late, or on the wrong edge, would send `sample[0]` where `tx_sig` belongs, or the reverse. It drives a second sync pulse into the middle of a frame. A design that restarted on it would cut the byte short or add a second strobe. It also checks every release cause, both at the point where the pins should let go and at the point where they should come back. A design that set the enable again as soon as the cause cleared, without waiting for a fresh sync, would drive the highway in the middle of another channel's timeslot. So would a design that needed master-clock edges to detect a stopped clock.

// File: rtl/pcm_tx_pkg.sv
// Package: types shared by the PCM transmit framer modules.
// Assumes an 8-bit companded sample per frame.
package pcm_tx_pkg;
    localparam int unsigned SAMPLE_W = 8;

    typedef logic [SAMPLE_W-1:0] sample_t;

    typedef enum logic {
        KIND_VOICE  = 1'b0,
        KIND_SIGNAL = 1'b1
    } frame_kind_e;
endpackage

// File: rtl/pcm_tx_sync_det.sv
// Frame-sync detector: emits a one-cycle start on the rising edge of fs,
// but only when no frame is shifting. On the clock after a start it marks
// the frame as signaling if fs is still high. Assumes fs is synchronous to clk.
module pcm_tx_sync_det (
    input  logic clk,
    input  logic rst_n,
    input  logic fs,
    input  logic busy,
    output logic start,
    output logic sig_mark
);
    logic fs_q;
    logic start_q;

    // Remember the previous fs level and whether a frame just started.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fs_q    <= 1'b0;
            start_q <= 1'b0;
        end else begin
            fs_q    <= fs;
            start_q <= start;
        end
    end

    assign start    = fs & ~fs_q & ~busy;
    assign sig_mark = fs & start_q;

    // A start is never followed by another start on the next clock.
    assert_single_start_R6: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> !start);
endmodule

// File: rtl/pcm_tx_shifter.sv
// Serializer: captures the sample at start, shifts it out MSB first one bit per clock
// and keeps busy (the strobe) high for exactly SAMPLE_W clocks. In a signaling frame
// the last slot takes tx_sig. Assumes sig_mark only arrives one clock after start.
module pcm_tx_shifter
    import pcm_tx_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    start,
    input  logic    sig_mark,
    input  sample_t sample,
    input  logic    tx_sig,
    output logic    dx,
    output logic    busy
);
    localparam int unsigned CNT_W = $clog2(SAMPLE_W);

    sample_t     sh;
    logic [CNT_W-1:0] cnt;
    frame_kind_e kind;

    // Load on start, then one shift per clock until the slot count runs out.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh   <= '0;
            cnt  <= '0;
            busy <= 1'b0;
            kind <= KIND_VOICE;
            dx   <= 1'b0;
        end else if (start) begin
            dx   <= sample[SAMPLE_W-1];
            sh   <= sample << 1;
            cnt  <= CNT_W'(SAMPLE_W - 1);
            busy <= 1'b1;
            kind <= KIND_VOICE;
        end else if (busy) begin
            if (sig_mark) begin
                kind <= KIND_SIGNAL;
            end
            if (cnt != '0) begin
                if (cnt == CNT_W'(1)) begin
                    dx <= (kind == KIND_SIGNAL || sig_mark) ? tx_sig : sh[SAMPLE_W-1];
                end else begin
                    dx <= sh[SAMPLE_W-1];
                end
                sh  <= sh << 1;
                cnt <= cnt - CNT_W'(1);
            end else begin
                busy <= 1'b0;
            end
        end
    end

    // The first bit on the line is the captured MSB, and the strobe is active.
    assert_msb_first_R3: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (busy && dx == $past(sample[SAMPLE_W-1])));

    // The strobe only ends once every slot has been sent.
    assert_strobe_len_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> ($past(cnt) == '0));

    // Mid-frame syncs never reload the slot counter.
    assert_no_reload_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && cnt != '0) |=> (busy && cnt == $past(cnt) - CNT_W'(1)));
endmodule

// File: rtl/pcm_tx_guard.sv
// Output guard: decides in the clk domain whether the pads may drive.
// Any release cause clears the enable. Only an accepted start can set it again,
// and only once the power-up holdoff has counted HOLD_FRAMES starts.
// Assumes lost_w is a level from the watchdog domain; it is synchronized here.
module pcm_tx_guard #(
    parameter int unsigned HOLD_FRAMES = 4,
    parameter int unsigned STBY_CYCLES = 46320
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic pdn_n,
    input  logic lost_w,
    output logic drive_ok
);
    localparam int unsigned HW = $clog2(HOLD_FRAMES + 1);
    localparam int unsigned IW = $clog2(STBY_CYCLES + 1);

    logic          pdn_q;
    logic          lost_m;
    logic          lost_s;
    logic [HW-1:0] hold_cnt;
    logic [IW-1:0] idle_cnt;
    logic          hold_done;
    logic          stby;
    logic          clr;

    assign hold_done = (hold_cnt == HW'(HOLD_FRAMES));
    assign stby      = (idle_cnt == IW'(STBY_CYCLES));
    assign clr       = ~pdn_q | lost_s | (stby & ~start);

    // Register the power-down pin and bring the clock-loss flag into this domain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pdn_q  <= 1'b0;
            lost_m <= 1'b0;
            lost_s <= 1'b0;
        end else begin
            pdn_q  <= pdn_n;
            lost_m <= lost_w;
            lost_s <= lost_m;
        end
    end

    // Count accepted starts until the power-up holdoff is over.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_cnt <= '0;
        end else if (start && !hold_done) begin
            hold_cnt <= hold_cnt + HW'(1);
        end
    end

    // Measure the clocks since the last accepted start, saturating at the standby limit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idle_cnt <= '0;
        end else if (start) begin
            idle_cnt <= '0;
        end else if (!stby) begin
            idle_cnt <= idle_cnt + IW'(1);
        end
    end

    // Drive enable: any release cause clears it; an accepted start sets it after the holdoff.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            drive_ok <= 1'b0;
        end else if (clr) begin
            drive_ok <= 1'b0;
        end else if (start) begin
            drive_ok <= hold_done;
        end
    end

    assert_holdoff_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !hold_done) |=> !drive_ok);

    assert_pdn_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !pdn_q |=> !drive_ok);

    assert_standby_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (stby && !start) |=> !drive_ok);

    assert_clkloss_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
        lost_s |=> !drive_ok);
endmodule

// File: rtl/pcm_tx_clkmon.sv
// Clock-loss monitor: clk toggles a heartbeat bit. The watchdog domain synchronizes
// it and counts the ticks with no change. After LOSS_TICKS quiet ticks it raises lost.
// Assumes the watchdog period is not an even multiple of the clk period.
module pcm_tx_clkmon #(
    parameter int unsigned LOSS_TICKS = 20
) (
    input  logic clk,
    input  logic wdt_clk,
    input  logic rst_n,
    output logic lost
);
    localparam int unsigned LW = $clog2(LOSS_TICKS + 1);

    logic          beat;
    logic          s1, s2, s3;
    logic [LW-1:0] quiet;

    // Heartbeat that changes on every master-clock edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            beat <= 1'b0;
        end else begin
            beat <= ~beat;
        end
    end

    // Synchronize the heartbeat and count the watchdog ticks with no change.
    always_ff @(posedge wdt_clk) begin
        if (!rst_n) begin
            s1    <= 1'b0;
            s2    <= 1'b0;
            s3    <= 1'b0;
            quiet <= '0;
        end else begin
            s1 <= beat;
            s2 <= s1;
            s3 <= s2;
            if (s2 != s3) begin
                quiet <= '0;
            end else if (quiet != LW'(LOSS_TICKS)) begin
                quiet <= quiet + LW'(1);
            end
        end
    end

    assign lost = (quiet == LW'(LOSS_TICKS));

    // Seeing the clock again always withdraws the loss flag on the next tick.
    assert_loss_clear_R9: assert property (@(posedge wdt_clk) disable iff (!rst_n)
        (s2 != s3) |=> !lost);
endmodule

// File: rtl/pcm_tx_framer.sv
// Top: PCM transmit framer. Detects frame sync and serializes the sample under
// the timeslot strobe. It also gates the pad drive enable with the guard and the
// clock-loss monitor. Assumes fs, pdn_n and the inputs are synchronous to clk.
module pcm_tx_framer
    import pcm_tx_pkg::*;
#(
    parameter int unsigned HOLD_FRAMES = 4,
    parameter int unsigned STBY_CYCLES = 46320,
    parameter int unsigned LOSS_TICKS  = 20
) (
    input  logic                clk,
    input  logic                wdt_clk,
    input  logic                rst_n,
    input  logic                pdn_n,
    input  logic                fs,
    input  logic [SAMPLE_W-1:0] sample,
    input  logic                tx_sig,
    output logic                dx,
    output logic                ts_n,
    output logic                out_en
);
    logic start;
    logic sig_mark;
    logic busy;
    logic drive_ok;
    logic lost;

    pcm_tx_sync_det u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .fs       (fs),
        .busy     (busy),
        .start    (start),
        .sig_mark (sig_mark)
    );

    pcm_tx_shifter u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .sig_mark (sig_mark),
        .sample   (sample),
        .tx_sig   (tx_sig),
        .dx       (dx),
        .busy     (busy)
    );

    pcm_tx_guard #(
        .HOLD_FRAMES (HOLD_FRAMES),
        .STBY_CYCLES (STBY_CYCLES)
    ) u_guard (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .pdn_n    (pdn_n),
        .lost_w   (lost),
        .drive_ok (drive_ok)
    );

    pcm_tx_clkmon #(
        .LOSS_TICKS (LOSS_TICKS)
    ) u_clkmon (
        .clk     (clk),
        .wdt_clk (wdt_clk),
        .rst_n   (rst_n),
        .lost    (lost)
    );

    assign ts_n   = ~busy;
    assign out_en = drive_ok & ~lost;

    // The strobe is inactive whenever reset holds the block.
    assert_reset_idle_R1: assert property (@(posedge clk)
        !rst_n |=> ts_n);
endmodule

// File: tb/test_pcm_tx_framer.sv
module test_pcm_tx_framer;
    localparam int HOLD  = 4;
    localparam int STBY  = 300;
    localparam int LOSS  = 8;
    localparam int FRAME = 48;

    logic clk = 1'b0;
    logic clk_run = 1'b1;
    logic wdt_clk = 1'b0;
    logic rst_n = 1'b0;
    logic pdn_n = 1'b1;
    logic fs = 1'b0;
    logic [7:0] sample = '0;
    logic tx_sig = 1'b0;
    logic dx, ts_n, out_en;

    int checks = 0;
    int errors = 0;

    // 250 MHz master clock that can be stopped (low) for the clock-loss case.
    always #2 clk = clk_run ? ~clk : 1'b0;

    // Watchdog oscillator, 50 MHz, phase-shifted off the master-clock edges.
    initial begin
        #1;
        forever #10 wdt_clk = ~wdt_clk;
    end

    pcm_tx_framer #(
        .HOLD_FRAMES (HOLD),
        .STBY_CYCLES (STBY),
        .LOSS_TICKS  (LOSS)
    ) i_pcm_tx_framer (
        .clk     (clk),
        .wdt_clk (wdt_clk),
        .rst_n   (rst_n),
        .pdn_n   (pdn_n),
        .fs      (fs),
        .sample  (sample),
        .tx_sig  (tx_sig),
        .dx      (dx),
        .ts_n    (ts_n),
        .out_en  (out_en)
    );

    task automatic chk(input string req, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Expected bit on dx after edge E0+k.
    function automatic logic exp_bit(input logic [7:0] b, input bit wide, input bit sg,
                                     input int k);
        if (k == 7 && wide) return sg;
        return b[7-k];
    endfunction

    // One frame: sync of width 1 or 2, optional stray sync in mid-frame, checks per slot.
    task automatic send_frame(input logic [7:0] b, input bit wide, input bit sg,
                              input bit en_exp, input string en_req, input bit mid);
        @(negedge clk);
        sample = b;
        tx_sig = sg;
        fs     = 1'b1;
        for (int k = 0; k <= 8; k++) begin
            @(posedge clk);
            @(negedge clk);
            if (k < 8) begin
                chk(k == 7 ? "R5" : "R3", $sformatf("bit slot %0d", k), dx,
                    exp_bit(b, wide, sg, k));
                chk("R4", "strobe low in slot", ts_n, 1'b0);
            end else begin
                chk("R4", "strobe high after 8 slots", ts_n, 1'b1);
            end
            if (k == 0 || k == 8) chk(en_req, "out_en", out_en, en_exp);
            if ((k == 0 && !wide) || (k == 1 && wide)) fs = 1'b0;
            if (mid && k == 3) fs = 1'b1;
            if (mid && k == 4) fs = 1'b0;
        end
        if (mid) begin
            for (int j = 0; j < 4; j++) begin
                @(negedge clk);
                chk("R6", "no second strobe", ts_n, 1'b1);
            end
            repeat (FRAME - 13) @(posedge clk);
        end else begin
            repeat (FRAME - 9) @(posedge clk);
        end
    endtask

    task automatic run_all();
        logic [7:0] b;
        bit w, s;
        void'($urandom(32'd2718));

        // R1: reset state.
        repeat (30) @(negedge clk);
        chk("R1", "out_en in reset", out_en, 1'b0);
        chk("R1", "ts_n in reset", ts_n, 1'b1);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        chk("R1", "out_en after reset", out_en, 1'b0);
        chk("R1", "ts_n after reset", ts_n, 1'b1);

        // R2: holdoff frames stay released, the next frame drives.
        for (int f = 0; f < HOLD; f++) begin
            b = 8'($urandom_range(0, 255));
            send_frame(b, f[0], 1'b1, 1'b0, "R2", 1'b0);
        end
        send_frame(8'h3C, 1'b0, 1'b0, 1'b1, "R2", 1'b0);

        // R3, R4, R5: random samples and mixed sync widths.
        for (int f = 0; f < 20; f++) begin
            b = 8'($urandom_range(0, 255));
            w = 1'($urandom_range(0, 1));
            s = 1'($urandom_range(0, 1));
            send_frame(b, w, s, 1'b1, "R3", 1'b0);
        end

        // R5: directed last-slot cases.
        send_frame(8'hA5, 1'b0, 1'b0, 1'b1, "R5", 1'b0);
        send_frame(8'hA5, 1'b1, 1'b0, 1'b1, "R5", 1'b0);
        send_frame(8'h00, 1'b1, 1'b1, 1'b1, "R5", 1'b0);
        send_frame(8'hFF, 1'b0, 1'b0, 1'b1, "R5", 1'b0);

        // R6: stray sync in the middle of a frame.
        send_frame(8'h96, 1'b0, 1'b1, 1'b1, "R6", 1'b1);
        send_frame(8'h69, 1'b1, 1'b0, 1'b1, "R6", 1'b1);

        // R7: power-down releases, and only a fresh sync after it restores drive.
        @(negedge clk);
        pdn_n = 1'b0;
        @(posedge clk);
        @(posedge clk);
        @(negedge clk);
        chk("R7", "out_en two edges after pdn low", out_en, 1'b0);
        send_frame(8'h5A, 1'b0, 1'b0, 1'b0, "R7", 1'b0);
        @(negedge clk);
        pdn_n = 1'b1;
        repeat (5) @(negedge clk);
        chk("R7", "out_en before fresh sync", out_en, 1'b0);
        send_frame(8'hC3, 1'b0, 1'b0, 1'b1, "R7", 1'b0);

        // R8: standby after missing syncs, recovery on the next sync.
        repeat (200) @(negedge clk);
        chk("R8", "out_en before standby limit", out_en, 1'b1);
        repeat (70) @(negedge clk);
        chk("R8", "out_en after standby limit", out_en, 1'b0);
        send_frame(8'h81, 1'b1, 1'b1, 1'b1, "R8", 1'b0);

        // R9: clock loss seen by the watchdog, recovery needs clock plus sync.
        @(negedge clk);
        chk("R9", "out_en before clock stop", out_en, 1'b1);
        clk_run = 1'b0;
        #40;
        chk("R9", "out_en shortly after clock stop", out_en, 1'b1);
        #280;
        chk("R9", "out_en after watchdog timeout", out_en, 1'b0);
        #1;
        clk_run = 1'b1;
        repeat (60) @(negedge clk);
        chk("R9", "out_en with clock back, no sync", out_en, 1'b0);
        send_frame(8'h7E, 1'b0, 1'b0, 1'b1, "R9", 1'b0);
    endtask

    initial begin
        fork
            run_all();
            begin
                #1_000_000;
                checks++;
                errors++;
                $display("FAIL watchdog: actual=hung expected=done");
            end
        join_any
        disable fork;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule